// File: doc/BRIEF.md
# Secured Configuration Access Controller

This block guards access to the configuration store of a programmable logic device. It keeps a small word-addressed fuse array, a one-bit security fuse, a 64-bit user signature held as eight bytes, and a bank of preloadable state bits that is visible at an output. Requests arrive one at a time on a valid/ready command port. Each accepted request produces exactly one response beat, which carries read data and a denied flag.

Once the security fuse is set, two kinds of request are refused: verify reads of the fuse array and preloads of the state bits. The refusal starts with the very next command. A refused verify returns zeros. A refused preload leaves the state bits as they were. The user signature can be read and written at any time, whether or not the fuse is set. The only way to clear the security fuse is a full erase. A full erase also wipes the fuse array and the signature.

Commands are encoded on a 3-bit operation field. Programming writes a word into the array and is accepted even on a secured device. A secured device can therefore still be configured but cannot be read back.

Top module: `cfg_guard`

## Requirements
- R1: `cmd_ready` is high whenever no response is pending. When a command is accepted (`cmd_valid` and `cmd_ready` both high at a clock edge), `rsp_valid` is high for exactly the following cycle, and `cmd_ready` is low during that cycle.
- R2: Operation 0 (program) writes `cmd_data` into array word `cmd_addr`, whether or not the device is secured. Operation 1 (verify) on an unsecured device returns that word with `rsp_denied` low.
- R3: Operation 1 (verify) on a secured device returns all-zero data with `rsp_denied` high, and `rsp_denied` lasts only for that one response cycle.
- R4: Operation 2 (preload) on an unsecured device loads `cmd_data` into `preload_q`. The new value is visible in the response cycle, and `rsp_denied` is low.
- R5: Operation 2 (preload) on a secured device leaves `preload_q` unchanged and responds with `rsp_denied` high and zero data.
- R6: Operation 3 (signature write) stores `cmd_data` into signature byte `cmd_addr[2:0]`. Operation 4 (signature read) returns that byte with `rsp_denied` low. Both work the same way whether or not the device is secured.
- R7: Operation 5 (secure) sets the security fuse. The command immediately after it already sees the device as secured.
- R8: Operation 6 (full erase) zeroes every array word and every signature byte and clears the security fuse. `preload_q` is not affected.
- R9: After reset, `cmd_ready` is high, `rsp_valid` and `rsp_denied` are low, `preload_q` is zero, every array word reads zero, and the device is unsecured.
- R10: Operation 7 is reserved. It responds with zero data and `rsp_denied` high, and it changes no state.
- R11: Responses to write-type operations (0, 3, 5 and 6) and to an allowed preload carry zero data with `rsp_denied` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Array word address, or signature byte index in the low bits |
| cmd_data | input | DATA_W | Write or preload data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Read data, zero when none or refused |
| rsp_denied | output | 1 | Request refused by the security fuse or reserved opcode |
| preload_q | output | DATA_W | Current preloadable state bits |

## Verification
A wrong fuse bit would show up on the first verify or preload after it went wrong. Data would leak or the denied flag would be missing in that response, or `preload_q` would move when it should hold. A corrupted array or signature byte only becomes visible when that exact location is read back. For this reason the bench reads back the written locations after securing, after signature traffic and after erase. A handshake fault shows at once as a response with no matching command, or as a `cmd_ready` that is high during a response beat.

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int SIG_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_denied,
  output logic [DATA_W-1:0] preload_q
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SIG_W = $clog2(SIG_BYTES);

  localparam logic [2:0] OP_PROG   = 3'd0;
  localparam logic [2:0] OP_VERIFY = 3'd1;
  localparam logic [2:0] OP_PRE    = 3'd2;
  localparam logic [2:0] OP_SIGWR  = 3'd3;
  localparam logic [2:0] OP_SIGRD  = 3'd4;
  localparam logic [2:0] OP_SECURE = 3'd5;
  localparam logic [2:0] OP_ERASE  = 3'd6;

  logic [DATA_W-1:0] arr_q [DEPTH];
  logic [DATA_W-1:0] sig_q [SIG_BYTES];
  logic              fuse_q;
  logic              deny_c;
  logic [DATA_W-1:0] rdata_c;
  logic [SIG_W-1:0]  sidx;

  wire accept = cmd_valid & cmd_ready;
  assign cmd_ready = ~rsp_valid;
  assign sidx = cmd_addr[SIG_W-1:0];

  always_comb begin
    deny_c  = 1'b0;
    rdata_c = '0;
    case (cmd_op)
      OP_VERIFY: begin
        deny_c  = fuse_q;
        rdata_c = fuse_q ? '0 : arr_q[cmd_addr];
      end
      OP_PRE:   deny_c  = fuse_q;
      OP_SIGRD: rdata_c = sig_q[sidx];
      OP_PROG, OP_SIGWR, OP_SECURE, OP_ERASE: ;
      default:  deny_c  = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_denied <= 1'b0;
      fuse_q     <= 1'b0;
      preload_q  <= '0;
      for (int i = 0; i < DEPTH; i++) arr_q[i] <= '0;
      for (int i = 0; i < SIG_BYTES; i++) sig_q[i] <= '0;
    end else begin
      rsp_valid  <= accept;
      rsp_data   <= accept ? rdata_c : '0;
      rsp_denied <= accept & deny_c;
      if (accept) begin
        case (cmd_op)
          OP_PROG:   arr_q[cmd_addr] <= cmd_data;
          OP_PRE:    if (!fuse_q) preload_q <= cmd_data;
          OP_SIGWR:  sig_q[sidx] <= cmd_data;
          OP_SECURE: fuse_q <= 1'b1;
          OP_ERASE: begin
            fuse_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) arr_q[i] <= '0;
            for (int i = 0; i < SIG_BYTES; i++) sig_q[i] <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  p_accept_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);
  p_rsp_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
  p_deny_in_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_denied |-> (rsp_valid && rsp_data == '0));
  p_preload_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_denied) |-> $stable(preload_q));
  p_secure_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_q && !(accept && cmd_op == OP_ERASE)) |=> fuse_q);
  p_erase_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_ERASE) |=> !fuse_q);
endmodule

// File: tb/test_cfg_guard.sv
`timescale 1ns/1ps
module test_cfg_guard;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_denied;
  logic [DW-1:0] preload_q;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_data_q [$];
  logic          exp_den_q  [$];
  string         exp_req_q  [$];

  always #10 clk = ~clk;

  cfg_guard #(.ADDR_W(AW), .DATA_W(DW), .SIG_BYTES(8)) i_cfg_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_denied(rsp_denied),
    .preload_q(preload_q)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [DW-1:0] ed,
                      input logic eden, input string req);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    exp_data_q.push_back(ed);
    exp_den_q.push_back(eden);
    exp_req_q.push_back(req);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_data_q.size() == 0) begin
        check("R1", "unexpected response", 1, 0);
      end else begin
        automatic string r = exp_req_q.pop_front();
        automatic logic [DW-1:0] ed = exp_data_q.pop_front();
        automatic logic en = exp_den_q.pop_front();
        check(r, "rsp_data", rsp_data, ed);
        check(r, "rsp_denied", rsp_denied, en);
        check("R1", "cmd_ready during response", cmd_ready, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R9", "cmd_ready after reset", cmd_ready, 1);
    check("R9", "rsp_valid after reset", rsp_valid, 0);
    check("R9", "rsp_denied after reset", rsp_denied, 0);
    check("R9", "preload_q after reset", preload_q, 0);
    send(3'd1, 4'd5, 8'h00, 8'h00, 1'b0, "R9");
    send(3'd1, 4'd15, 8'h00, 8'h00, 1'b0, "R9");

    send(3'd0, 4'd3, 8'hA5, 8'h00, 1'b0, "R11");
    send(3'd0, 4'd15, 8'h3C, 8'h00, 1'b0, "R11");
    send(3'd1, 4'd3, 8'h00, 8'hA5, 1'b0, "R2");
    send(3'd1, 4'd15, 8'h00, 8'h3C, 1'b0, "R2");

    send(3'd2, 4'd0, 8'h5A, 8'h00, 1'b0, "R4");
    check("R4", "preload_q loaded", preload_q, 8'h5A);

    send(3'd3, 4'd0, 8'h11, 8'h00, 1'b0, "R6");
    send(3'd3, 4'd7, 8'h77, 8'h00, 1'b0, "R6");
    send(3'd4, 4'd0, 8'h00, 8'h11, 1'b0, "R6");
    send(3'd4, 4'd7, 8'h00, 8'h77, 1'b0, "R6");

    send(3'd7, 4'd3, 8'hFF, 8'h00, 1'b1, "R10");
    check("R10", "preload_q after reserved", preload_q, 8'h5A);
    send(3'd1, 4'd3, 8'h00, 8'hA5, 1'b0, "R10");

    send(3'd5, 4'd0, 8'h00, 8'h00, 1'b0, "R11");
    send(3'd1, 4'd3, 8'h00, 8'h00, 1'b1, "R7");
    send(3'd1, 4'd15, 8'h00, 8'h00, 1'b1, "R3");
    check("R3", "denied lasts one cycle", rsp_denied, 1);
    @(negedge clk);
    check("R3", "denied dropped", rsp_denied, 0);

    send(3'd2, 4'd0, 8'hFF, 8'h00, 1'b1, "R5");
    check("R5", "preload_q held when secured", preload_q, 8'h5A);

    send(3'd4, 4'd7, 8'h00, 8'h77, 1'b0, "R6");
    send(3'd3, 4'd3, 8'h33, 8'h00, 1'b0, "R6");
    send(3'd4, 4'd3, 8'h00, 8'h33, 1'b0, "R6");
    send(3'd0, 4'd4, 8'hC3, 8'h00, 1'b0, "R2");

    send(3'd6, 4'd0, 8'h00, 8'h00, 1'b0, "R11");
    check("R8", "preload_q kept by erase", preload_q, 8'h5A);
    send(3'd1, 4'd3, 8'h00, 8'h00, 1'b0, "R8");
    send(3'd1, 4'd4, 8'h00, 8'h00, 1'b0, "R8");
    send(3'd4, 4'd0, 8'h00, 8'h00, 1'b0, "R8");
    send(3'd4, 4'd7, 8'h00, 8'h00, 1'b0, "R8");
    send(3'd2, 4'd0, 8'h12, 8'h00, 1'b0, "R8");
    check("R8", "preload allowed after erase", preload_q, 8'h12);

    send(3'd0, 4'd9, 8'h96, 8'h00, 1'b0, "R2");
    send(3'd1, 4'd9, 8'h00, 8'h96, 1'b0, "R2");

    repeat (3) @(negedge clk);
    check("R1", "all responses seen", exp_data_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule